// File: doc/BRIEF.md
# Unaligned Partial-Word Load/Store Merge Unit

This unit carries out the left and right partial-word memory operations on 32-bit words and 64-bit doublewords. A load of this kind fetches the aligned memory unit that holds the addressed byte. It shifts that data by a byte count taken from the low address bits and merges it into the old register value under a byte mask. A store of this kind also fetches the aligned memory unit, places the shifted register bytes into it, and writes the merged unit back. The store is therefore a read-modify-write. A pair of left and right operations on the two ends of an unaligned field reads or writes the whole field.

The surrounding pipeline pulses `start_i` with an operation code, the effective address, the old register contents and the result of address translation. While it is busy, the unit drives a simple request/acknowledge memory port. When it finishes, it pulses `done_o` for one cycle. In that cycle it presents either a register result with its write enable or an exception flag. A translation fault stops the operation before any memory request is made.

Operation code `op_i`: bit 2 selects store (1) or load (0). Bit 1 selects doubleword (1) or word (0). Bit 0 selects the right form (1) or the left form (0).

The controller has four states:
- IDLE: waiting for a start.
- READ: the read request is held until it is acknowledged.
- WRITE: the write request is held until it is acknowledged. Stores only.
- DONE: a one-cycle completion state.

Its transitions are:
- IDLE→READ on a start without a fault.
- IDLE→DONE on a start with a fault.
- READ→WRITE on acknowledge for a store.
- READ→DONE on acknowledge for a load.
- WRITE→DONE on acknowledge.
- DONE→IDLE always.

Top module: `ulsm_unit`

## Requirements
- R1: After reset the unit is in IDLE, and `busy_o`, `done_o`, `mem_req_o`, `rd_we_o` and `exc_o` are all low.
- R2: A left word load (op 3'b000) with byte offset a = addr[1:0] sets result bytes a..3 to memory bytes 0..3-a. Result bytes below a keep the old register bytes. Bit 31 of the result is sign-extended to 64 bits.
- R3: A right word load (op 3'b001) with a = addr[1:0] sets result bytes 0..a to memory bytes 3-a..3. The remaining low-word bytes keep the old register bytes. Bit 31 of the result is sign-extended to 64 bits.
- R4: The doubleword loads (op 3'b010 left, 3'b011 right) follow the same byte rules over 8 bytes, with a = addr[2:0]. The 64-bit result is not sign-extended.
- R5: Every memory request carries the operation address with the low 2 bits cleared for word forms and the low 3 bits cleared for doubleword forms. For word forms, the fetched word is taken from `mem_rdata_i[31:0]`.
- R6: A left store (op 3'b100 word, 3'b110 doubleword) writes register bytes a..k into memory bytes 0..k-a, where k is 3 or 7. The other memory bytes keep the values that were read.
- R7: A right store (op 3'b101 word, 3'b111 doubleword) writes register bytes 0..a into memory bytes k-a..k. The other memory bytes keep the values that were read.
- R8: Word stores use only the low 32 bits of the register value and drive `mem_wdata_o[63:32]` to zero.
- R9: A start with `xlate_fault_i` high issues no memory request. The unit reaches DONE on the next cycle with `exc_o` high, `rd_we_o` low, and `exc_store_o` equal to op bit 2.
- R10: A load performs exactly one read and no write, then asserts `rd_we_o` in DONE. A store performs exactly one read followed by one write and never asserts `rd_we_o`.
- R11: `done_o` is high for exactly one cycle per operation.
- R12: While a request waits for acknowledge, `mem_req_o`, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted in IDLE |
| op_i | input | 3 | Operation code: store, doubleword, right |
| addr_i | input | 64 | Effective byte address |
| reg_old_i | input | 64 | Old register value (load merge base or store source) |
| xlate_fault_i | input | 1 | Address translation failed |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 64 | Aligned memory address |
| mem_wdata_o | output | 64 | Merged write data |
| mem_rdata_i | input | 64 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Request acknowledge |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_we_o | output | 1 | Register write enable (loads, with done) |
| rd_data_o | output | 64 | Register result |
| exc_o | output | 1 | Translation exception, with done |
| exc_store_o | output | 1 | Exception came from a store form |

## Verification
Several properties are checked by assertions on every cycle: address alignment on each request, a stable request while acknowledge is pending, the single-cycle done pulse, the fault path going straight to DONE with an exception and no request, a store read always being followed by a write, and the register write enable never coinciding with an exception. The byte-level merge results can only be confirmed by the bench's scenarios, because they depend on offset, form and data. These include sign extension of word loads and the zero upper half of word store data. The scenarios also confirm the exact number of reads and writes per operation.

// File: rtl/ulsm_pkg.sv
package ulsm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } ulsm_state_e;

    localparam int OP_W       = 3;
    localparam int OP_STORE_B = 2;
    localparam int OP_DBL_B   = 1;
    localparam int OP_RIGHT_B = 0;

endpackage

// File: rtl/ulsm_lane.sv
module ulsm_lane #(
    parameter int W = 32
) (
    input  logic                          right_i,
    input  logic                          store_i,
    input  logic [$clog2(W/8)-1:0]        lo_i,
    input  logic [W-1:0]                  mem_i,
    input  logic [W-1:0]                  reg_i,
    output logic [W-1:0]                  res_o
);
    localparam int NB = W / 8;
    localparam int LA = $clog2(NB);
    localparam int SW = $clog2(W);

    logic [SW-1:0] sh_fwd;
    logic [SW-1:0] sh_rev;
    logic [W-1:0]  ones;
    logic [W-1:0]  mask;

    always_comb begin
        ones   = '1;
        sh_fwd = {lo_i, 3'b000};
        sh_rev = {lo_i ^ LA'(NB - 1), 3'b000};
        unique case ({store_i, right_i})
            2'b00: begin
                mask  = ones << sh_fwd;
                res_o = (reg_i & ~mask) | (mem_i << sh_fwd);
            end
            2'b01: begin
                mask  = ones >> sh_rev;
                res_o = (reg_i & ~mask) | (mem_i >> sh_rev);
            end
            2'b10: begin
                mask  = ones >> sh_fwd;
                res_o = (mem_i & ~mask) | (reg_i >> sh_fwd);
            end
            default: begin
                mask  = ones << sh_rev;
                res_o = (mem_i & ~mask) | (reg_i << sh_rev);
            end
        endcase
    end

endmodule

// File: rtl/ulsm_ctrl.sv
module ulsm_ctrl
    import ulsm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        fault_i,
    input  logic        is_store_i,
    input  logic        ack_i,
    output ulsm_state_e state_o,
    output logic        accept_o,
    output logic        rd_ack_o,
    output logic        mem_req_o,
    output logic        mem_we_o,
    output logic        busy_o,
    output logic        done_o
);
    ulsm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = fault_i ? ST_DONE : ST_READ;
            ST_READ:  if (ack_i)   state_d = is_store_i ? ST_WRITE : ST_DONE;
            ST_WRITE: if (ack_i)   state_d = ST_DONE;
            ST_DONE:               state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept_o  = 1'b0;
        rd_ack_o  = 1'b0;
        mem_req_o = 1'b0;
        mem_we_o  = 1'b0;
        busy_o    = 1'b1;
        done_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o   = 1'b0;
                accept_o = start_i;
            end
            ST_READ: begin
                mem_req_o = 1'b1;
                rd_ack_o  = ack_i;
            end
            ST_WRITE: begin
                mem_req_o = 1'b1;
                mem_we_o  = 1'b1;
            end
            ST_DONE:  done_o = 1'b1;
            default:  busy_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

    // R9
    fault_skips_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && fault_i) |=> (done_o && !mem_req_o));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    store_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && ack_i && is_store_i) |=> (mem_req_o && mem_we_o));

    // R10
    load_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && ack_i && !is_store_i) |=> (done_o && !mem_req_o));

endmodule

// File: rtl/ulsm_unit.sv
module ulsm_unit
    import ulsm_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] reg_old_i,
    input  logic              xlate_fault_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_ack_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              rd_we_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              exc_o,
    output logic              exc_store_o
);
    localparam int HW = DATA_W / 2;
    localparam int NB = DATA_W / 8;

    logic [OP_W-1:0]   op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] reg_q;
    logic [DATA_W-1:0] memd_q;
    logic              flt_q;

    ulsm_state_e state;
    logic        accept, rd_ack;

    ulsm_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .fault_i    (xlate_fault_i),
        .is_store_i (op_q[OP_STORE_B]),
        .ack_i      (mem_ack_i),
        .state_o    (state),
        .accept_o   (accept),
        .rd_ack_o   (rd_ack),
        .mem_req_o  (mem_req_o),
        .mem_we_o   (mem_we_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= '0;
            addr_q <= '0;
            reg_q  <= '0;
            memd_q <= '0;
            flt_q  <= 1'b0;
        end else begin
            if (accept) begin
                op_q   <= op_i;
                addr_q <= addr_i;
                reg_q  <= reg_old_i;
                flt_q  <= xlate_fault_i;
            end
            if (rd_ack) memd_q <= mem_rdata_i;
        end
    end

    // index 0: word lane, index 1: doubleword lane
    logic [DATA_W-1:0] lane_res [2];

    for (genvar g = 0; g < 2; g++) begin : g_lane
        localparam int LW = (g == 0) ? HW : DATA_W;
        localparam int LA = $clog2(LW / 8);
        logic [LW-1:0] res;
        ulsm_lane #(.W(LW)) u_lane (
            .right_i (op_q[OP_RIGHT_B]),
            .store_i (op_q[OP_STORE_B]),
            .lo_i    (addr_q[LA-1:0]),
            .mem_i   (memd_q[LW-1:0]),
            .reg_i   (reg_q[LW-1:0]),
            .res_o   (res)
        );
        assign lane_res[g] = DATA_W'(res);
    end

    logic              is_dbl, is_st, ok_load;
    logic [ADDR_W-1:0] low_clr;

    always_comb begin
        is_dbl  = op_q[OP_DBL_B];
        is_st   = op_q[OP_STORE_B];
        low_clr = is_dbl ? ADDR_W'(NB - 1) : ADDR_W'(NB / 2 - 1);
        ok_load = done_o && !flt_q && !is_st;

        mem_addr_o  = addr_q & ~low_clr;
        mem_wdata_o = '0;
        if (mem_we_o)
            mem_wdata_o = is_dbl ? lane_res[1] : lane_res[0];

        rd_we_o   = ok_load;
        rd_data_o = '0;
        if (ok_load)
            rd_data_o = is_dbl ? lane_res[1]
                               : {{(DATA_W - HW){lane_res[0][HW-1]}}, lane_res[0][HW-1:0]};

        exc_o       = done_o && flt_q;
        exc_store_o = done_o && flt_q && is_st;
    end

    // R5
    aligned_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[1:0] == 2'b00 &&
                       (!op_q[OP_DBL_B] || mem_addr_o[2] == 1'b0)));

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o) &&
                                       $stable(mem_addr_o) && $stable(mem_wdata_o)));

    // R9
    fault_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && xlate_fault_i) |=> (exc_o && !rd_we_o));

    // R10
    no_we_on_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_we_o && exc_o));

    // R8
    word_store_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && !op_q[OP_DBL_B]) |-> (mem_wdata_o[DATA_W-1:HW] == '0));

endmodule

// File: tb/sim_ulsm_unit.sv
`timescale 1ns/1ps
module sim_ulsm_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [63:0] addr_i = '0;
    logic [63:0] reg_old_i = '0;
    logic        xlate_fault_i = 1'b0;
    logic        mem_req_o, mem_we_o;
    logic [63:0] mem_addr_o, mem_wdata_o;
    logic [63:0] mem_rdata_i = '0;
    logic        mem_ack_i = 1'b0;
    logic        busy_o, done_o, rd_we_o, exc_o, exc_store_o;
    logic [63:0] rd_data_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ulsm_unit u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .addr_i(addr_i),
        .reg_old_i(reg_old_i), .xlate_fault_i(xlate_fault_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i),
        .busy_o(busy_o), .done_o(done_o), .rd_we_o(rd_we_o), .rd_data_o(rd_data_o),
        .exc_o(exc_o), .exc_store_o(exc_store_o)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(logic [2:0] op, logic flt);
        if (flt) return "R9";
        case (op)
            3'b000: return "R2";
            3'b001: return "R3";
            3'b010, 3'b011: return "R4";
            3'b100, 3'b110: return "R6";
            default: return "R7";
        endcase
    endfunction

    // byte-lane reference model
    function automatic logic [63:0] ref_merge(logic [2:0] op, logic [63:0] addr,
                                              logic [63:0] rg, logic [63:0] mv);
        int n = op[1] ? 8 : 4;
        int k = n - 1;
        int a = int'(addr[2:0]) & k;
        logic [63:0] r = '0;
        for (int i = 0; i < n; i++) begin
            case ({op[2], op[0]})
                2'b00: r[i*8 +: 8] = (i >= a)     ? mv[(i-a)*8 +: 8]     : rg[i*8 +: 8];
                2'b01: r[i*8 +: 8] = (i <= a)     ? mv[(i+k-a)*8 +: 8]   : rg[i*8 +: 8];
                2'b10: r[i*8 +: 8] = (i <= k - a) ? rg[(i+a)*8 +: 8]     : mv[i*8 +: 8];
                default: r[i*8 +: 8] = (i >= k - a) ? rg[(i-k+a)*8 +: 8] : mv[i*8 +: 8];
            endcase
        end
        if (!op[2] && !op[1]) r[63:32] = {32{r[31]}};
        return r;
    endfunction

    task automatic run_op(logic [2:0] op, logic [63:0] addr, logic [63:0] rg,
                          logic [63:0] mv, logic flt);
        int nrd = 0, nwr = 0, waited = 0, lat;
        logic [63:0] raddr = '0, waddr = '0, wdat = '0;
        logic got_done = 0, d_we = 0, d_exc = 0, d_exs = 0;
        logic [63:0] d_data = '0;
        logic [63:0] al = addr & ~(op[1] ? 64'd7 : 64'd3);
        string rq = req_of(op, flt);
        lat = $urandom_range(0, 2);
        @(negedge clk);
        op_i = op; addr_i = addr; reg_old_i = rg; xlate_fault_i = flt; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c < 40 && !got_done; c++) begin
            mem_ack_i = 1'b0;
            if (done_o) begin
                got_done = 1; d_we = rd_we_o; d_exc = exc_o; d_exs = exc_store_o;
                d_data = rd_data_o;
            end else begin
                if (mem_req_o) begin
                    if (waited >= lat) begin
                        mem_ack_i = 1'b1;
                        mem_rdata_i = mv;
                        if (mem_we_o) begin nwr++; waddr = mem_addr_o; wdat = mem_wdata_o; end
                        else begin nrd++; raddr = mem_addr_o; end
                        waited = 0;
                        lat = $urandom_range(0, 2);
                    end else waited++;
                end
                @(negedge clk);
            end
        end
        mem_ack_i = 1'b0;
        chk("R11", "done seen", 64'(got_done), 64'd1);
        if (flt) begin
            chk(rq, "reads", 64'(nrd), 0);
            chk(rq, "writes", 64'(nwr), 0);
            chk(rq, "exc", 64'(d_exc), 1);
            chk(rq, "exc_store", 64'(d_exs), 64'(op[2]));
            chk(rq, "rd_we", 64'(d_we), 0);
        end else begin
            chk("R10", "reads", 64'(nrd), 1);
            chk("R10", "writes", 64'(nwr), 64'(op[2]));
            chk(rq, "exc", 64'(d_exc), 0);
            chk("R5", "read addr", raddr, al);
            if (op[2]) begin
                chk("R10", "rd_we", 64'(d_we), 0);
                chk("R5", "write addr", waddr, al);
                chk(op[1] ? rq : "R8", "wdata", wdat, ref_merge(op, addr, rg, mv));
            end else begin
                chk("R10", "rd_we", 64'(d_we), 1);
                chk(rq, "rd_data", d_data, ref_merge(op, addr, rg, mv));
            end
        end
        @(negedge clk);
        chk("R11", "done after pulse", 64'(done_o), 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        chk("R1", "busy", 64'(busy_o), 0);
        chk("R1", "done", 64'(done_o), 0);
        chk("R1", "req", 64'(mem_req_o), 0);
        chk("R1", "rd_we", 64'(rd_we_o), 0);
        chk("R1", "exc", 64'(exc_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed: every form at every offset, sign bit set in memory
        for (int op = 0; op < 8; op++)
            for (int a = 0; a < 8; a++)
                run_op(3'(op), 64'h0000_1000 + 64'(a),
                       64'h1122_3344_5566_7788, 64'h8899_AABB_CCDD_EEFF, 1'b0);
        // directed: positive word for sign extension, high register half on word store
        run_op(3'b000, 64'h20, 64'hFFFF_FFFF_0000_0000, 64'h0000_0000_7F00_0001, 1'b0);
        run_op(3'b001, 64'h23, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_7F00_0001, 1'b0);
        run_op(3'b100, 64'h40, 64'hDEAD_BEEF_0102_0304, 64'hCAFE_F00D_A5A5_A5A5, 1'b0);
        // directed faults, load and store
        run_op(3'b000, 64'h11, 64'h1, 64'h2, 1'b1);
        run_op(3'b111, 64'h17, 64'h1, 64'h2, 1'b1);

        for (int i = 0; i < 300; i++)
            run_op(3'($urandom_range(0, 7)), {$urandom, $urandom},
                   {$urandom, $urandom}, {$urandom, $urandom},
                   ($urandom_range(0, 9) == 0));

        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule